// File: doc/BRIEF.md
# Dual-Mode Multilevel Inverter PWM Gate Controller

This block turns a signed, already sampled sinusoidal reference into the eleven gate signals of a multilevel inverter bridge, using level-shifted multicarrier PWM. One up/down counter drives a stack of triangular carriers. The carriers sit in bands of equal height, one above the other, across the reference range. Carriers at or above zero all run in phase. Carriers below zero are inverted. Every enabled band is compared with the reference, and the signed sum of the comparator results is the output level. That level selects an eleven-bit switch pattern.

Two operating modes are supported. The switched-capacitor mode uses six carriers and produces levels −3..+3. Its non-negative levels use a fixed switch pattern built into the block. The asymmetric-source mode uses fourteen carriers and produces levels −7..+7. All of its patterns, and the negative patterns of the switched-capacitor mode, come from a writable pattern table indexed by the signed level.

A dead-time stage sits in front of the gate outputs. When a new pattern arrives, switches that turn off drop at once, while switches that turn on stay low for a programmable number of clocks. A mode request made while running is applied only when the level is zero. While enable is low, every gate is off.

Top module: `mlpwm_gate_ctrl`

## Requirements
- R1: While `en_i` is low the carrier count is 0 and counting upward. Each enabled clock moves the count by one. It rises 0,1,…,P, then falls P−1,…,0, then rises again, where P is `per_i`. With P = 0 the count stays 0.
- R2: Band k uses carrier value k·P+c for k ≥ 0 and k·P+(P−c) for k < 0, where c is the count. A band with k ≥ 0 adds +1 when its carrier is less than the reference. A band with k < 0 adds −1 when its carrier is greater than the reference. The summed level appears on `level_o` at the clock edge after the sample, using the count held before that edge.
- R3: Mode 0 (`mode_i`=0) uses bands k = −3..2, so its level is limited to −3..+3. Mode 1 uses bands k = −7..6, so its level is limited to −7..+7.
- R4: In mode 0, levels 0, +1, +2 and +3 give the fixed patterns 0x5BA, 0x3BA, 0x36E and 0x366, where bit i of `gate_o` drives switch S(i+1). With zero dead time, `gate_o` shows the pattern of the level one clock after the level appears.
- R5: The pattern table has 15 entries, for levels −7..+7. Each entry is zero after reset. One entry is written per clock in which `tbl_we_i` is high, at the level given by `tbl_lvl_i` (two's complement). The table supplies every pattern in mode 1 and the negative-level patterns in mode 0.
- R6: When the selected pattern changes, bits that turn off fall at the same edge. Bits that turn on stay low for `dt_i` clocks and rise at the `dt_i`-th edge after the change. With `dt_i` = 0 the new pattern is applied at once.
- R7: With `en_i` low, `gate_o` is zero and `level_o` is zero after the next clock edge. When enable is raised, the first pattern is treated as turning on from all-off.
- R8: A change of `mode_i` while enabled takes effect only on a clock edge at which the registered level is 0. While disabled, the mode follows `mode_i` at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low forces gates off |
| mode_i | input | 1 | Requested mode: 0 = seven-level, 1 = fifteen-level |
| ref_i | input | 16 | Signed reference sample |
| per_i | input | 12 | Carrier peak count P (carrier period is 2P clocks) |
| dt_i | input | 8 | Dead-time length in clocks for turning-on switches |
| tbl_we_i | input | 1 | Pattern table write strobe |
| tbl_lvl_i | input | 5 | Signed level selecting the table entry to write |
| tbl_pat_i | input | 11 | Pattern written into the table |
| gate_o | output | 11 | Gate drive vector, bit i drives S(i+1) |
| level_o | output | 5 | Signed output level currently selected |

## Verification
The gate stage is a state machine with three states: ST_OFF (all gates off), ST_RUN (pattern driven) and ST_HOLD (newly-on bits masked while the dead-time counter runs). It moves ST_OFF→ST_RUN or ST_HOLD on enable, ST_RUN→ST_HOLD on a pattern change with nonzero dead time, ST_HOLD→ST_RUN when the count expires, ST_HOLD→ST_HOLD when a new pattern restarts the count, and any state→ST_OFF on disable.

A carrier count that drifts or reverses at the wrong point shows up on `level_o` within one clock, once the reference lies near a band edge. It is caught by sampling at known count positions on both the rising and falling slopes. A wrong band offset or phase sign shows as a level off by one for that reference. A stale mode or pattern register shows on `gate_o` one clock after the level. A dead-time counter that is off by one shows as an early or late rising bit, counted from the edge of the pattern change.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int NSW   = 11;
    localparam int LVL_W = 5;

    typedef enum logic {
        MODE_SC7  = 1'b0,
        MODE_AS15 = 1'b1
    } mode_e;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } gate_st_e;

    // Fixed switched-capacitor patterns for levels 0..3, bit i = switch S(i+1)
    function automatic logic [NSW-1:0] sc7_fixed(input logic [1:0] lvl);
        logic [NSW-1:0] p;
        unique case (lvl)
            2'd0:    p = 11'h5BA;
            2'd1:    p = 11'h3BA;
            2'd2:    p = 11'h36E;
            default: p = 11'h366;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mlpwm_carrier_gen.sv
module mlpwm_carrier_gen #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PER_W-1:0] per_i,
    output logic [PER_W-1:0] cnt_o
);
    import mlpwm_pkg::*;

    logic [PER_W-1:0] cnt_q;
    dir_e             dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || per_i == '0) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            unique case (dir_q)
                DIR_UP: begin
                    if (cnt_q >= per_i) begin
                        dir_q <= DIR_DN;
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        dir_q <= DIR_UP;
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign cnt_o = cnt_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $stable(per_i) && per_i != '0)
        |-> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == $past(cnt_o) - 1'b1));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(per_i) && $past(cnt_o) <= per_i) |-> (cnt_o <= per_i));

endmodule

// File: rtl/mlpwm_level_sum.sv
module mlpwm_level_sum #(
    parameter int REF_W = 16,
    parameter int PER_W = 12,
    parameter int NC7   = 6,
    parameter int NC15  = 14,
    parameter int LVL_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  mlpwm_pkg::mode_e        mode_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [PER_W-1:0]        per_i,
    input  logic [PER_W-1:0]        cnt_i,
    output logic signed [LVL_W-1:0] level_o
);
    import mlpwm_pkg::*;

    localparam int HALF  = NC15 / 2;
    localparam int HALF7 = NC7 / 2;
    localparam int ACC_W = ((REF_W > PER_W + 5) ? REF_W : PER_W + 5) + 1;

    logic signed [ACC_W-1:0] per_s;
    logic signed [ACC_W-1:0] cnt_s;
    logic signed [ACC_W-1:0] ref_s;
    logic [NC15-1:0]         pos_hit;
    logic [NC15-1:0]         neg_hit;
    logic [NC15-1:0]         act;
    logic signed [LVL_W-1:0] sum;
    logic signed [LVL_W-1:0] level_q;

    assign per_s = $signed({{(ACC_W-PER_W){1'b0}}, per_i});
    assign cnt_s = $signed({{(ACC_W-PER_W){1'b0}}, cnt_i});
    assign ref_s = ACC_W'(ref_i);

    for (genvar b = 0; b < NC15; b++) begin : g_band
        localparam int K   = b - HALF;
        localparam bit IN7 = (K >= -HALF7) && (K < HALF7);
        logic signed [ACC_W-1:0] car;
        if (K >= 0) begin : g_pos
            assign car        = ACC_W'(K) * per_s + cnt_s;
            assign pos_hit[b] = (car < ref_s);
            assign neg_hit[b] = 1'b0;
        end else begin : g_neg
            assign car        = ACC_W'(K) * per_s + (per_s - cnt_s);
            assign neg_hit[b] = (car > ref_s);
            assign pos_hit[b] = 1'b0;
        end
        assign act[b] = (mode_i == MODE_AS15) || IN7;
    end

    always_comb begin
        sum = '0;
        for (int b = 0; b < NC15; b++) begin
            if (act[b] && pos_hit[b]) sum = sum + LVL_W'(1);
            if (act[b] && neg_hit[b]) sum = sum - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) level_q <= '0;
        else                  level_q <= sum;
    end

    assign level_o = level_q;

    // R3
    sc7_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_SC7)
        |-> (level_o >= -LVL_W'(HALF7) && level_o <= LVL_W'(HALF7)));

endmodule

// File: rtl/mlpwm_pattern_map.sv
module mlpwm_pattern_map #(
    parameter int NSW   = 11,
    parameter int LVL_W = 5,
    parameter int NC7   = 6,
    parameter int NC15  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic signed [LVL_W-1:0] wr_lvl_i,
    input  logic [NSW-1:0]          wr_pat_i,
    input  mlpwm_pkg::mode_e        mode_i,
    input  logic signed [LVL_W-1:0] level_i,
    output logic [NSW-1:0]          pat_o
);
    import mlpwm_pkg::*;

    localparam int HALF  = NC15 / 2;
    localparam int HALF7 = NC7 / 2;
    localparam int NLV   = NC15 + 1;

    logic [NSW-1:0] tbl_q [NLV];
    logic [NSW-1:0] tbl_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLV; i++) tbl_q[i] <= '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < NLV; i++) begin
                if (wr_lvl_i == LVL_W'(i - HALF)) tbl_q[i] <= wr_pat_i;
            end
        end
    end

    always_comb begin
        tbl_rd = '0;
        for (int i = 0; i < NLV; i++) begin
            if (level_i == LVL_W'(i - HALF)) tbl_rd = tbl_q[i];
        end
    end

    always_comb begin
        if (mode_i == MODE_SC7 && level_i >= 0 && level_i <= LVL_W'(HALF7))
            pat_o = sc7_fixed(level_i[1:0]);
        else
            pat_o = tbl_rd;
    end

endmodule

// File: rtl/mlpwm_deadtime_fsm.sv
module mlpwm_deadtime_fsm #(
    parameter int NSW  = 11,
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [DT_W-1:0] dt_i,
    input  logic [NSW-1:0]  target_i,
    output logic [NSW-1:0]  gate_o
);
    import mlpwm_pkg::*;

    gate_st_e        state_q, state_d;
    logic [NSW-1:0]  pat_q;
    logic [NSW-1:0]  mask_q;
    logic [DT_W-1:0] cnt_q;
    logic            change;
    logic            load;

    assign change = (target_i != pat_q);
    assign load   = en_i && ((state_q == ST_OFF) || change);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = (dt_i == '0) ? ST_RUN : ST_HOLD;
            end
            ST_RUN: begin
                if (!en_i)       state_d = ST_OFF;
                else if (change) state_d = (dt_i == '0) ? ST_RUN : ST_HOLD;
            end
            ST_HOLD: begin
                if (!en_i)                     state_d = ST_OFF;
                else if (change)               state_d = (dt_i == '0) ? ST_RUN : ST_HOLD;
                else if (cnt_q <= DT_W'(1))    state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // pattern, mask and dead-time counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pat_q  <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            pat_q  <= target_i;
            mask_q <= (dt_i == '0) ? '0 : (target_i & ~gate_o);
            cnt_q  <= dt_i;
        end else if (state_d == ST_RUN) begin
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (state_q == ST_HOLD) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_HOLD: gate_o = pat_q & ~mask_q;
            default:         gate_o = '0;
        endcase
    end

    // R7
    off_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (gate_o == '0));

    // R6
    rise_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_i != '0 && $stable(dt_i) && ((gate_o & ~$past(gate_o)) != '0))
        |-> $stable(pat_q));

    // R6
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q != '0));

endmodule

// File: rtl/mlpwm_gate_ctrl.sv
module mlpwm_gate_ctrl #(
    parameter int REF_W = 16,
    parameter int PER_W = 12,
    parameter int DT_W  = 8,
    parameter int NC7   = 6,
    parameter int NC15  = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en_i,
    input  logic                              mode_i,
    input  logic signed [REF_W-1:0]           ref_i,
    input  logic [PER_W-1:0]                  per_i,
    input  logic [DT_W-1:0]                   dt_i,
    input  logic                              tbl_we_i,
    input  logic signed [mlpwm_pkg::LVL_W-1:0] tbl_lvl_i,
    input  logic [mlpwm_pkg::NSW-1:0]         tbl_pat_i,
    output logic [mlpwm_pkg::NSW-1:0]         gate_o,
    output logic signed [mlpwm_pkg::LVL_W-1:0] level_o
);
    import mlpwm_pkg::*;

    mode_e                   mode_q;
    logic [PER_W-1:0]        cnt;
    logic signed [LVL_W-1:0] level_q;
    logic [NSW-1:0]          target;

    // mode register: follows request when idle or at a zero level
    always_ff @(posedge clk) begin
        if (!rst_n)                      mode_q <= MODE_SC7;
        else if (!en_i || level_q == '0) mode_q <= mode_e'(mode_i);
    end

    mlpwm_carrier_gen #(.PER_W(PER_W)) u_car (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (en_i),
        .per_i (per_i),
        .cnt_o (cnt)
    );

    mlpwm_level_sum #(
        .REF_W (REF_W),
        .PER_W (PER_W),
        .NC7   (NC7),
        .NC15  (NC15),
        .LVL_W (LVL_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (en_i),
        .mode_i  (mode_q),
        .ref_i   (ref_i),
        .per_i   (per_i),
        .cnt_i   (cnt),
        .level_o (level_q)
    );

    mlpwm_pattern_map #(
        .NSW   (NSW),
        .LVL_W (LVL_W),
        .NC7   (NC7),
        .NC15  (NC15)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (tbl_we_i),
        .wr_lvl_i (tbl_lvl_i),
        .wr_pat_i (tbl_pat_i),
        .mode_i   (mode_q),
        .level_i  (level_q),
        .pat_o    (target)
    );

    mlpwm_deadtime_fsm #(
        .NSW  (NSW),
        .DT_W (DT_W)
    ) u_dt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .dt_i     (dt_i),
        .target_i (target),
        .gate_o   (gate_o)
    );

    assign level_o = level_q;

    // R8
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(level_q) == '0 || !$past(en_i)));

    // R7
    off_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (level_q == '0));

endmodule

// File: tb/mlpwm_gate_ctrl_tb.sv
`timescale 1ns/1ps
module mlpwm_gate_ctrl_tb;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               en;
    logic               mode;
    logic signed [15:0] ref_v;
    logic [11:0]        per;
    logic [7:0]         dt;
    logic               tbl_we;
    logic signed [4:0]  tbl_lvl;
    logic [10:0]        tbl_pat;
    logic [10:0]        gate;
    logic signed [4:0]  level;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    mlpwm_gate_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .mode_i    (mode),
        .ref_i     (ref_v),
        .per_i     (per),
        .dt_i      (dt),
        .tbl_we_i  (tbl_we),
        .tbl_lvl_i (tbl_lvl),
        .tbl_pat_i (tbl_pat),
        .gate_o    (gate),
        .level_o   (level)
    );

    // mode, reference, enabled edges, expected level (P = 100)
    localparam int VEC [14][4] = '{
        '{0,     0,   1,  0},
        '{0,   150,  21,  2},
        '{0,   150,  61,  1},
        '{0,  -150,  21, -2},
        '{0,  -150,  61, -1},
        '{0,  1000,  11,  3},
        '{0, -1000,  11, -3},
        '{1,  1000,  11,  7},
        '{1, -1000,  11, -7},
        '{1,   450,  31,  5},
        '{1,  -450,  31, -5},
        '{1,   450,  71,  4},
        '{0,   150, 181,  2},
        '{0,   150, 141,  1}
    };

    function automatic logic [10:0] tpat(input int l);
        return 11'(((l + 8) * 37) & 2047);
    endfunction

    function automatic int exp_pat(input int m, input int l);
        if (m == 0 && l >= 0) begin
            case (l)
                0:       return 'h5BA;
                1:       return 'h3BA;
                2:       return 'h36E;
                default: return 'h366;
            endcase
        end
        return int'(tpat(l));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic run_vec(input int m, input int r, input int e, input int exp_l,
                           input int exp_g, input string tl, input string tg);
        en    = 1'b0;
        mode  = m[0];
        ref_v = 16'(r);
        @(negedge clk);
        en = 1'b1;
        repeat (e) @(negedge clk);
        chk(int'(level) == exp_l, tl, int'(level), exp_l);
        @(negedge clk);
        chk(int'(gate) == exp_g, tg, int'(gate), exp_g);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..all: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; mode = 1'b0; ref_v = '0; per = 12'd100;
        dt = '0; tbl_we = 1'b0; tbl_lvl = '0; tbl_pat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate == '0, "R7 reset gate", int'(gate), 0);
        chk(level == '0, "R7 reset level", int'(level), 0);

        // R5: table entries are zero before any write
        run_vec(0, -1000, 11, -3, 0, "R3 level neg sat", "R5 default entry");

        for (int l = -7; l <= 7; l++) begin
            tbl_we  = 1'b1;
            tbl_lvl = 5'(l);
            tbl_pat = tpat(l);
            @(negedge clk);
        end
        tbl_we = 1'b0;

        for (int i = 0; i < 14; i++) begin
            string tl, tg;
            tl = (i >= 12) ? "R1 level on falling slope" :
                 (i >= 5 && i <= 8) ? "R3 level saturation" : "R2 level";
            tg = (VEC[i][0] == 0 && VEC[i][3] >= 0) ? "R4 fixed pattern" : "R5 table pattern";
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                    exp_pat(VEC[i][0], VEC[i][3]), tl, tg);
        end

        // R6: dead time on turn-on, immediate turn-off
        en = 1'b0; mode = 1'b0; ref_v = 16'sd1000; dt = 8'd4;
        @(negedge clk);
        en = 1'b1;
        repeat (5) @(negedge clk);
        chk(gate == '0, "R6 turn-on held", int'(gate), 0);
        @(negedge clk);
        chk(gate == 11'h366, "R6 turn-on released", int'(gate), 'h366);
        ref_v = -16'sd1000;
        repeat (2) @(negedge clk);
        chk(gate == 11'h020, "R6 turn-off immediate", int'(gate), 'h020);
        repeat (3) @(negedge clk);
        chk(gate == 11'h020, "R6 new bits still held", int'(gate), 'h020);
        @(negedge clk);
        chk(gate == 11'h0B9, "R6 new bits released", int'(gate), 'h0B9);

        // R8: mode request waits for a zero level
        dt = '0; ref_v = 16'sd1000; mode = 1'b1;
        repeat (4) @(negedge clk);
        chk(level == 5'sd3, "R8 mode change deferred", int'(level), 3);
        ref_v = '0;
        repeat (2) @(negedge clk);
        ref_v = 16'sd1000;
        repeat (2) @(negedge clk);
        chk(level == 5'sd7, "R8 mode applied at zero", int'(level), 7);
        chk(gate == 11'h22B, "R8 mode-1 pattern", int'(gate), 'h22B);

        // R7: disable forces gates and level off
        en = 1'b0;
        @(negedge clk);
        chk(gate == '0, "R7 disabled gate", int'(gate), 0);
        chk(level == '0, "R7 disabled level", int'(level), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule